// File: doc/BRIEF.md
# Reconfigurable Region Swap Controller

This block manages one reconfigurable region of a device. A control processor asks for a module variant by index. The block then looks up where that variant's partial bitstream sits inside a shared configuration memory image, and streams the bitstream one word at a time into the device's configuration port. Only one member of the region's mutually exclusive set of modules is resident at any time. Each request replaces the current occupant.

The swap always runs in the same order. First, the region's outputs are fenced off from the static logic. Next, the configuration words are written. Then the region's reset is held low for a fixed number of cycles. Last, the fence is removed and a one-cycle completion pulse is given. For the whole swap, the streaming channels that cross the region boundary are stalled, so producers and consumers on either side block until the new module is live. A chip places one instance of this controller per region.

The memory image opens with a table of contents. Entry k occupies word addresses 2k and 2k+1. The first word holds the bitstream's byte offset from the image base, and the second holds its length in 32-bit words. The memory port returns read data one cycle after the read is issued, and it holds that data until the next read.

Top module: `region_swap_ctrl`

## Requirements
- R1: When idle, a request whose index is below NUM_MODULES is accepted at the clock edge that samples it. From the next cycle, `busy` is high and stays high up to and including the `done` cycle. After that cycle the block returns to idle.
- R2: For an accepted index k, the block reads word 2k of the image as a byte offset and word 2k+1 as a length in words. Bitstream word i is then fetched from word address offset/4 + i.
- R3: Exactly `length` configuration words are presented on `cfg_data` with `cfg_valid`, in ascending address order. A presented word and its valid stay unchanged until `cfg_ready` accepts it.
- R4: `region_isolate` rises in the cycle after acceptance. It is high in every cycle in which a configuration word is presented.
- R5: After the last word is accepted, `region_rst_n` is low for exactly RST_CYCLES consecutive cycles (16 by default). `region_isolate` stays high throughout that window.
- R6: In the cycle after the reset window, `done` is high for exactly one cycle. In that cycle `region_isolate` is low and `region_rst_n` is high.
- R7: While `busy` is high, `r_in_valid`, `s_in_ready`, `s_out_valid` and `r_out_ready` are all forced to zero. While idle, each channel's valid and ready pass straight through.
- R8: A request with an index at or above NUM_MODULES raises `err` for one cycle. In that case `busy` stays low, no memory read is issued, and isolation and region reset stay inactive.
- R9: A request that arrives while `busy` is high is ignored. The swap in progress completes with its own word count, and no second swap follows.
- R10: A table entry with length zero presents no configuration word. It still runs the full isolate, reset and release sequence.
- R11: `mem_rd_en` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Swap request strobe from the control processor |
| req_index | input | IDX_W | Index of the module variant to load |
| busy | output | 1 | Swap in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse on an out-of-range request |
| mem_rd_en | output | 1 | Image memory read strobe |
| mem_addr | output | ADDR_W | Image memory word address |
| mem_rdata | input | 32 | Read data, valid one cycle after the strobe and held until the next read |
| cfg_valid | output | 1 | Configuration word present |
| cfg_data | output | 32 | Configuration word |
| cfg_ready | input | 1 | Configuration port accepts the word |
| region_isolate | output | 1 | Fences region outputs off from the static logic |
| region_rst_n | output | 1 | Active-low reset to the region |
| s_in_valid | input | NUM_IN | Static-side valid for channels into the region |
| s_in_ready | output | NUM_IN | Ready returned to the static producers |
| r_in_valid | output | NUM_IN | Valid delivered to the region |
| r_in_ready | input | NUM_IN | Ready from the region's input side |
| r_out_valid | input | NUM_OUT | Valid from the region's output side |
| r_out_ready | output | NUM_OUT | Ready delivered to the region |
| s_out_valid | output | NUM_OUT | Valid delivered to the static consumers |
| s_out_ready | input | NUM_OUT | Ready from the static consumers |

## Verification
A sequencer that skips or reorders a phase shows up at the ports within a cycle. Examples are a configuration word appearing without isolation, a reset pulse that overlaps the release, or a stall that lifts before `done`. A wrong table read, pointer or length counter shows up as the wrong data value or the wrong number of accepted words before the reset window begins. A faulty reset timer changes the length of the low window on `region_rst_n` and moves `done` by the same number of cycles. The bench therefore records every accepted word and every low reset cycle across each swap. It runs each swap under several `cfg_ready` patterns so that the hold behaviour is also covered.

// File: rtl/region_swap_pkg.sv
// Shared types for the region swap controller.
// Assumes nothing beyond a single clock domain.
package region_swap_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        SW_IDLE,
        SW_TOC_OFF,
        SW_TOC_LEN,
        SW_LEN_CAP,
        SW_FETCH,
        SW_SEND,
        SW_RESET,
        SW_DONE
    } swap_state_t;

endpackage

// File: rtl/region_swap_ptr.sv
// Word pointer and remaining-count tracker for the bitstream stream.
// Loads the start address from the table's byte offset (already shifted to
// words by the caller) and the length, then advances one word per accepted
// transfer. Assumes step is never raised with a zero remaining count.
module region_swap_ptr #(
    parameter int ADDR_W = 10,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_base,
    input  logic [ADDR_W-1:0] base_word,
    input  logic              load_len,
    input  logic [LEN_W-1:0]  len_words,
    input  logic              step,
    output logic [ADDR_W-1:0] word_addr,
    output logic              last
);

    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;

    // Track the next word address to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_base) begin
            addr_q <= base_word;
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(1);
        end
    end

    // Track how many words are still to be delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load_len) begin
            rem_q <= len_words;
        end else if (step) begin
            rem_q <= rem_q - LEN_W'(1);
        end
    end

    assign word_addr = addr_q;
    assign last      = (rem_q == LEN_W'(1));

endmodule

// File: rtl/region_swap_rst_timer.sv
// Counts the cycles of the region reset window.
// expire is high in the final cycle of a RST_CYCLES-long active stretch.
// Assumes active stays high until expire has been seen.
module region_swap_rst_timer #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expire
);

    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Count active cycles and clear outside the window.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign expire = active && (cnt_q == CNT_W'(RST_CYCLES - 1));

endmodule

// File: rtl/region_swap_gate.sv
// Stalls every streaming channel at the region boundary while hold is high.
// Otherwise it passes valid and ready through unchanged. Data lines do not
// pass through here; without a valid they carry no meaning.
module region_swap_gate #(
    parameter int NUM_IN  = 2,
    parameter int NUM_OUT = 2
) (
    input  logic               hold,
    input  logic [NUM_IN-1:0]  s_in_valid,
    output logic [NUM_IN-1:0]  s_in_ready,
    output logic [NUM_IN-1:0]  r_in_valid,
    input  logic [NUM_IN-1:0]  r_in_ready,
    input  logic [NUM_OUT-1:0] r_out_valid,
    output logic [NUM_OUT-1:0] r_out_ready,
    output logic [NUM_OUT-1:0] s_out_valid,
    input  logic [NUM_OUT-1:0] s_out_ready
);

    // One gate pair per channel into the region.
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
        assign r_in_valid[gi] = s_in_valid[gi] && !hold;
        assign s_in_ready[gi] = r_in_ready[gi] && !hold;
    end

    // One gate pair per channel out of the region.
    for (genvar go = 0; go < NUM_OUT; go++) begin : g_out
        assign s_out_valid[go] = r_out_valid[go] && !hold;
        assign r_out_ready[go] = s_out_ready[go] && !hold;
    end

endmodule

// File: rtl/region_swap_ctrl.sv
// Swap controller for one reconfigurable region.
// Accepts a module index, reads the image table of contents (entry k at word
// addresses 2k and 2k+1: byte offset, then word length), streams the
// bitstream over a valid/ready port, then pulses the region reset and
// releases isolation. Assumes read data arrives one cycle after mem_rd_en
// and holds until the next read, and that IDX_W + 1 <= ADDR_W.
module region_swap_ctrl
    import region_swap_pkg::*;
#(
    parameter int NUM_MODULES = 4,
    parameter int IDX_W       = 3,
    parameter int ADDR_W      = 10,
    parameter int RST_CYCLES  = 16,
    parameter int NUM_IN      = 2,
    parameter int NUM_OUT     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [IDX_W-1:0]   req_index,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               cfg_valid,
    output logic [WORD_W-1:0]  cfg_data,
    input  logic               cfg_ready,
    output logic               region_isolate,
    output logic               region_rst_n,
    input  logic [NUM_IN-1:0]  s_in_valid,
    output logic [NUM_IN-1:0]  s_in_ready,
    output logic [NUM_IN-1:0]  r_in_valid,
    input  logic [NUM_IN-1:0]  r_in_ready,
    input  logic [NUM_OUT-1:0] r_out_valid,
    output logic [NUM_OUT-1:0] r_out_ready,
    output logic [NUM_OUT-1:0] s_out_valid,
    input  logic [NUM_OUT-1:0] s_out_ready
);

    localparam int LEN_W = ADDR_W + 1;

    swap_state_t       state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic              err_q;
    logic              in_range;
    logic              accept;
    logic [ADDR_W-1:0] toc_addr;
    logic [ADDR_W-1:0] word_addr;
    logic              last_word;
    logic              rst_expire;
    logic              xfer;

    assign in_range = (int'(req_index) < NUM_MODULES);
    assign accept   = (state_q == SW_IDLE) && req_valid && in_range;
    assign toc_addr = ADDR_W'({idx_q, 1'b0});
    assign xfer     = (state_q == SW_SEND) && cfg_ready;

    // Next-state selection for the swap sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SW_IDLE:    if (accept) state_d = SW_TOC_OFF;
            SW_TOC_OFF: state_d = SW_TOC_LEN;
            SW_TOC_LEN: state_d = SW_LEN_CAP;
            SW_LEN_CAP: state_d = (mem_rdata == '0) ? SW_RESET : SW_FETCH;
            SW_FETCH:   state_d = SW_SEND;
            SW_SEND:    if (cfg_ready) state_d = last_word ? SW_RESET : SW_FETCH;
            SW_RESET:   if (rst_expire) state_d = SW_DONE;
            SW_DONE:    state_d = SW_IDLE;
            default:    state_d = SW_IDLE;
        endcase
    end

    // Hold the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SW_IDLE;
        else        state_q <= state_d;
    end

    // Latch the accepted module index.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (accept) idx_q <= req_index;
    end

    // Raise a one-cycle error for an out-of-range request seen while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (state_q == SW_IDLE) && req_valid && !in_range;
    end

    region_swap_ptr #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_base (state_q == SW_TOC_LEN),
        .base_word (mem_rdata[ADDR_W+1:2]),
        .load_len  (state_q == SW_LEN_CAP),
        .len_words (mem_rdata[LEN_W-1:0]),
        .step      (xfer),
        .word_addr (word_addr),
        .last      (last_word)
    );

    region_swap_rst_timer #(
        .RST_CYCLES (RST_CYCLES)
    ) u_rst_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state_q == SW_RESET),
        .expire (rst_expire)
    );

    region_swap_gate #(
        .NUM_IN  (NUM_IN),
        .NUM_OUT (NUM_OUT)
    ) u_gate (
        .hold        (busy),
        .s_in_valid  (s_in_valid),
        .s_in_ready  (s_in_ready),
        .r_in_valid  (r_in_valid),
        .r_in_ready  (r_in_ready),
        .r_out_valid (r_out_valid),
        .r_out_ready (r_out_ready),
        .s_out_valid (s_out_valid),
        .s_out_ready (s_out_ready)
    );

    // Drive the memory read port from the table and fetch phases.
    always_comb begin
        mem_rd_en = 1'b0;
        mem_addr  = '0;
        case (state_q)
            SW_TOC_OFF: begin mem_rd_en = 1'b1; mem_addr = toc_addr; end
            SW_TOC_LEN: begin mem_rd_en = 1'b1; mem_addr = toc_addr | ADDR_W'(1); end
            SW_FETCH:   begin mem_rd_en = 1'b1; mem_addr = word_addr; end
            default:    ;
        endcase
    end

    assign busy           = (state_q != SW_IDLE);
    assign done           = (state_q == SW_DONE);
    assign err            = err_q;
    assign cfg_valid      = (state_q == SW_SEND);
    assign cfg_data       = (state_q == SW_SEND) ? mem_rdata : '0;
    assign region_isolate = (state_q != SW_IDLE) && (state_q != SW_DONE);
    assign region_rst_n   = (state_q != SW_RESET);

endmodule

// File: rtl/region_swap_ctrl_chk.sv
// Property checker for region_swap_ctrl, attached by bind below.
// Watches only the top-level ports and a local reset-window counter.
module region_swap_ctrl_chk #(
    parameter int RST_CYCLES = 16,
    parameter int NUM_IN     = 2,
    parameter int NUM_OUT    = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic               err,
    input logic               mem_rd_en,
    input logic               cfg_valid,
    input logic [31:0]        cfg_data,
    input logic               cfg_ready,
    input logic               region_isolate,
    input logic               region_rst_n,
    input logic [NUM_IN-1:0]  s_in_ready,
    input logic [NUM_IN-1:0]  r_in_valid,
    input logic [NUM_OUT-1:0] r_out_ready,
    input logic [NUM_OUT-1:0] s_out_valid
);

    logic [31:0] low_cnt;

    // Count consecutive cycles of region reset.
    always_ff @(posedge clk) begin
        if (!rst_n)             low_cnt <= '0;
        else if (!region_rst_n) low_cnt <= low_cnt + 32'd1;
        else                    low_cnt <= '0;
    end

    // R1
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);

    // R3
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_data));

    // R4
    iso_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> region_isolate);

    // R5
    iso_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !region_rst_n |-> region_isolate);

    // R5
    rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(region_rst_n) |-> (low_cnt == 32'(RST_CYCLES)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R6
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !region_isolate && region_rst_n);

    // R7
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_in_valid == '0) && (s_in_ready == '0)
                 && (s_out_valid == '0) && (r_out_ready == '0));

    // R8
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy && !region_isolate);

    // R11
    rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> busy);

endmodule

bind region_swap_ctrl region_swap_ctrl_chk #(
    .RST_CYCLES (RST_CYCLES),
    .NUM_IN     (NUM_IN),
    .NUM_OUT    (NUM_OUT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy           (busy),
    .done           (done),
    .err            (err),
    .mem_rd_en      (mem_rd_en),
    .cfg_valid      (cfg_valid),
    .cfg_data       (cfg_data),
    .cfg_ready      (cfg_ready),
    .region_isolate (region_isolate),
    .region_rst_n   (region_rst_n),
    .s_in_ready     (s_in_ready),
    .r_in_valid     (r_in_valid),
    .r_out_ready    (r_out_ready),
    .s_out_valid    (s_out_valid)
);

// File: tb/region_swap_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for region_swap_ctrl: one task per scenario.
module region_swap_ctrl_tb;

    localparam int NUM_MODULES = 4;
    localparam int IDX_W       = 3;
    localparam int ADDR_W      = 10;
    localparam int RST_CYCLES  = 16;
    localparam int NUM_IN      = 2;
    localparam int NUM_OUT     = 2;
    localparam int MEM_WORDS   = 1 << ADDR_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic [IDX_W-1:0]   req_index = '0;
    logic               busy, done, err, mem_rd_en;
    logic [ADDR_W-1:0]  mem_addr;
    logic [31:0]        mem_rdata = '0;
    logic               cfg_valid;
    logic [31:0]        cfg_data;
    logic               cfg_ready = 1'b1;
    logic               region_isolate, region_rst_n;
    logic [NUM_IN-1:0]  s_in_valid = '1, s_in_ready, r_in_valid;
    logic [NUM_IN-1:0]  r_in_ready = '1;
    logic [NUM_OUT-1:0] r_out_valid = '1, r_out_ready, s_out_valid;
    logic [NUM_OUT-1:0] s_out_ready = '1;

    logic [31:0] mem [MEM_WORDS];

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Monitor state
    bit          mon_on = 0;
    int          rdy_mode = 0;
    int          phase = 0;
    logic [31:0] rec [64];
    int          nrec = 0;
    int          rst_low = 0;
    int          done_cnt = 0;
    int          viol_iso = 0;
    int          viol_stall = 0;
    int          viol_rd = 0;

    always #2 clk = ~clk;

    region_swap_ctrl #(
        .NUM_MODULES (NUM_MODULES),
        .IDX_W       (IDX_W),
        .ADDR_W      (ADDR_W),
        .RST_CYCLES  (RST_CYCLES),
        .NUM_IN      (NUM_IN),
        .NUM_OUT     (NUM_OUT)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_index (req_index),
        .busy (busy), .done (done), .err (err),
        .mem_rd_en (mem_rd_en), .mem_addr (mem_addr), .mem_rdata (mem_rdata),
        .cfg_valid (cfg_valid), .cfg_data (cfg_data), .cfg_ready (cfg_ready),
        .region_isolate (region_isolate), .region_rst_n (region_rst_n),
        .s_in_valid (s_in_valid), .s_in_ready (s_in_ready),
        .r_in_valid (r_in_valid), .r_in_ready (r_in_ready),
        .r_out_valid (r_out_valid), .r_out_ready (r_out_ready),
        .s_out_valid (s_out_valid), .s_out_ready (s_out_ready)
    );

    // Image memory: one-cycle read latency, data held between reads.
    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

    function automatic int mod_len(int k);
        case (k)
            0: return 3;
            1: return 6;
            2: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int mod_base(int k);
        return 32 + 16 * k;
    endfunction

    function automatic logic [31:0] word_at(int a);
        return 32'hC0DE_0000 + 32'(a);
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive cfg_ready from the pattern and sample outputs mid-cycle.
    always begin
        @(negedge clk);
        phase++;
        case (rdy_mode)
            0:       cfg_ready = 1'b1;
            1:       cfg_ready = phase[0];
            default: cfg_ready = (phase % 4 == 3);
        endcase
        #1;
        if (mon_on) begin
            if (cfg_valid && cfg_ready) begin
                if (nrec < 64) rec[nrec] = cfg_data;
                nrec++;
            end
            if (!region_rst_n) rst_low++;
            if (done) done_cnt++;
            if (cfg_valid && !region_isolate) viol_iso++;
            if (!region_rst_n && !region_isolate) viol_iso++;
            if (busy && (r_in_valid != '0 || s_in_ready != '0 ||
                         s_out_valid != '0 || r_out_ready != '0)) viol_stall++;
            if (mem_rd_en && !busy) viol_rd++;
        end
    end

    task automatic t_reset_state();
        @(negedge clk); #2;
        check(busy == 0 && done == 0, "R1", "idle after reset", {busy, done}, 0);
        check(err == 0 && mem_rd_en == 0, "R8", "no err or read after reset", {err, mem_rd_en}, 0);
        check(region_isolate == 0 && region_rst_n == 1, "R4", "region live after reset",
              {region_isolate, region_rst_n}, 2'b01);
        check(cfg_valid == 0, "R3", "no word after reset", cfg_valid, 0);
    endtask

    task automatic t_passthrough();
        @(negedge clk);
        s_in_valid = 2'b10; r_in_ready = 2'b01;
        r_out_valid = 2'b01; s_out_ready = 2'b10;
        #2;
        check(r_in_valid == 2'b10 && s_in_ready == 2'b01, "R7", "idle input passthrough",
              {r_in_valid, s_in_ready}, 4'b1001);
        check(s_out_valid == 2'b01 && r_out_ready == 2'b10, "R7", "idle output passthrough",
              {s_out_valid, r_out_ready}, 4'b0110);
        s_in_valid = '1; r_in_ready = '1; r_out_valid = '1; s_out_ready = '1;
    endtask

    // Full swap of module k; optionally injects a second request mid-swap.
    task automatic run_swap(int k, int mode, bit inject);
        int guard;
        int exp_len = mod_len(k);
        int base = mod_base(k);
        nrec = 0; rst_low = 0; done_cnt = 0;
        viol_iso = 0; viol_stall = 0; viol_rd = 0;
        rdy_mode = mode;
        mon_on = 1;
        @(negedge clk);
        req_valid = 1'b1; req_index = IDX_W'(k);
        @(negedge clk); #2;
        req_valid = 1'b0;
        check(busy == 1 && region_isolate == 1, "R1", "busy and isolate after accept",
              {busy, region_isolate}, 2'b11);
        guard = 0;
        while (done_cnt == 0 && guard < 2000) begin
            if (inject && guard == 4) begin req_valid = 1'b1; req_index = 3'd3; end
            if (inject && guard == 5) req_valid = 1'b0;
            @(negedge clk); #2;
            guard++;
        end
        check(done_cnt == 1, "R6", "single done pulse", done_cnt, 1);
        check(nrec == exp_len, (exp_len == 0) ? "R10" : "R3", "word count", nrec, exp_len);
        for (int i = 0; i < exp_len && i < nrec; i++)
            check(rec[i] == word_at(base + i), "R2", "word data", rec[i], word_at(base + i));
        check(rst_low == RST_CYCLES, "R5", "reset window length", rst_low, RST_CYCLES);
        check(viol_iso == 0, "R4", "isolation around load and reset", viol_iso, 0);
        check(viol_stall == 0, "R7", "channels stalled while busy", viol_stall, 0);
        @(negedge clk); #2;
        check(busy == 0 && done == 0 && region_isolate == 0 && region_rst_n == 1, "R6",
              "released and idle after done",
              {busy, done, region_isolate, region_rst_n}, 4'b0001);
        if (inject) begin
            for (int c = 0; c < 8; c++) begin
                @(negedge clk); #2;
                if (busy || cfg_valid) viol_stall++;
            end
            check(viol_stall == 0, "R9", "no second swap after ignored request", viol_stall, 0);
        end
        check(viol_rd == 0, "R11", "reads only while busy", viol_rd, 0);
        mon_on = 0;
        rdy_mode = 0;
    endtask

    task automatic t_reject(int k);
        @(negedge clk);
        req_valid = 1'b1; req_index = IDX_W'(k);
        @(negedge clk); #2;
        req_valid = 1'b0;
        check(err == 1, "R8", "err on out-of-range index", err, 1);
        check(busy == 0 && mem_rd_en == 0, "R8", "no swap started", {busy, mem_rd_en}, 0);
        check(region_isolate == 0 && region_rst_n == 1, "R8", "region untouched",
              {region_isolate, region_rst_n}, 2'b01);
        @(negedge clk); #2;
        check(err == 0 && busy == 0, "R8", "err is one cycle", {err, busy}, 0);
    endtask

    initial begin
        for (int a = 0; a < MEM_WORDS; a++) mem[a] = word_at(a);
        for (int k = 0; k < NUM_MODULES; k++) begin
            mem[2*k]     = 32'(mod_base(k) * 4);
            mem[2*k + 1] = 32'(mod_len(k));
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_passthrough();
        run_swap(0, 0, 0);
        run_swap(1, 1, 0);
        run_swap(2, 0, 0);
        run_swap(3, 2, 0);
        run_swap(0, 2, 0);
        t_reject(4);
        t_reject(7);
        run_swap(1, 0, 1);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule